// File: doc/BRIEF.md
# Burst-Detecting Event Counter

This block is one channel of a performance monitor. A 7-bit selector picks one of 128 event lines, and a counter advances on that event. The lower half of the selector range reaches events shared by every channel. The upper half reaches events private to this channel, and private event k is chosen with the value 64+k.

The channel has two counting modes. In the plain mode, each cycle in which the chosen event is high adds one. In the burst mode, the channel adds one for each burst. A burst is a tight cluster of occurrences that is preceded by a long quiet period. A freeze control stops the counter from advancing while event tracking goes on. An enable gates a condition flag that reflects the counter's top bit.

The control fields arrive as plain input ports and are expected to come from registers that reset to zero. With all fields at zero, the channel does plain counting, is not frozen, and has its condition flag disabled.

Top module: `burst_event_counter`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `countValue` is 0 and `ovfCondition` is 0.
- R2: An `eventSel` value below 64 selects `sharedEvents[eventSel]`. A value of 64 or more selects `chanEvents[eventSel-64]`.
- R3: With `burstSize` below 2, every clock cycle in which the selected event is high adds exactly one to the counter, visible after that clock edge.
- R4: While `freezeCnt` is 1, the counter keeps its value whatever the events do. Group tracking continues during freeze.
- R5: `ovfCondition` equals `condEnable` AND the most significant counter bit. It is 0 whenever `condEnable` is 0.
- R6: The counter is `CNT_W` bits wide (default 32). When it is all ones, an increment wraps it to zero.
- R7: With `burstSize` of 2 or more, consecutive occurrences whose gaps (cycle difference between occurrences) are each at most `burstGran` form one group. The counter adds one on the occurrence that brings the group to `burstSize` members. Further members of the same group add nothing.
- R8: An occurrence whose gap from the previous one exceeds `burstGran` does not join the previous group. A group that ends with fewer than `burstSize` members is never counted.
- R9: A new group can start only on an occurrence whose gap from the previous occurrence is at least `burstDist`, or on the first occurrence after reset. An occurrence with a gap greater than `burstGran` but less than `burstDist` blocks tracking: nothing is counted until a later occurrence with a gap of at least `burstDist`.
- R10: Activity on event lines that are not selected never changes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| freezeCnt | input | 1 | 1 holds the counter |
| condEnable | input | 1 | 1 lets the top counter bit raise the condition flag |
| eventSel | input | 7 | Event selector; 64+k picks private event k |
| burstSize | input | 5 | Members needed for a burst; below 2 selects plain counting |
| burstGran | input | 5 | Largest gap in cycles inside one group |
| burstDist | input | 6 | Smallest gap in cycles before a new group may start |
| sharedEvents | input | 64 | Events common to all channels |
| chanEvents | input | 64 | Events private to this channel |
| countValue | output | CNT_W | Counter value |
| ovfCondition | output | 1 | Overflow condition flag |

## Verification
The bench aims at the gap boundaries. A gap exactly equal to the granularity must stay in the group, and a gap exactly equal to the distance must open a new one. An off-by-one comparator would lose the first burst or count a blocked cluster. It also sends clusters that are too short, clusters spaced just above the granularity, and clusters that follow a quiet period shorter than the distance. A design that reset the group on every long gap, instead of blocking, would count these. Further checks cover the upper selector half, to catch a missing 64 offset; freeze, to catch a counter that drifts; and wrap-around at a reduced width, to catch a counter that saturates instead of wrapping or a flag that ignores its enable.

// File: rtl/bec_pkg.sv
package bec_pkg;
  // Strobes from the burst control to the counting datapath.
  typedef struct packed {
    logic hit;   // selected event present this cycle
    logic inc;   // counting rule says advance
  } cntStrobe_t;
endpackage

// File: rtl/bec_event_mux.sv
module bec_event_mux #(
  parameter int NUM_EV = 128,
  localparam int SEL_W = $clog2(NUM_EV),
  localparam int HALF  = NUM_EV / 2
) (
  input  logic [SEL_W-1:0] eventSel,
  input  logic [HALF-1:0]  sharedEvents,
  input  logic [HALF-1:0]  chanEvents,
  output logic             eventHit
);
  // Private events sit above the shared ones, so selector HALF+k lands on chanEvents[k].
  logic [NUM_EV-1:0] allEvents;
  assign allEvents = {chanEvents, sharedEvents};
  assign eventHit  = allEvents[eventSel];
endmodule

// File: rtl/bec_burst_ctrl.sv
module bec_burst_ctrl
  import bec_pkg::*;
#(
  parameter int SIZE_W = 5,
  parameter int GRAN_W = 5,
  parameter int DIST_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventHit,
  input  logic [SIZE_W-1:0] burstSize,
  input  logic [GRAN_W-1:0] burstGran,
  input  logic [DIST_W-1:0] burstDist,
  output cntStrobe_t        strobes
);
  // One spare bit so the saturated "long ago" value exceeds any programmed gap.
  localparam int GAP_W = ((DIST_W > GRAN_W) ? DIST_W : GRAN_W) + 1;
  localparam logic [GAP_W-1:0]  GAP_MAX = '1;
  localparam logic [SIZE_W-1:0] GRP_MAX = '1;

  logic [GAP_W-1:0]  sinceLast;
  logic [SIZE_W-1:0] groupCnt;
  logic [SIZE_W-1:0] nextGroup;
  logic              gapInside, distReached, burstMode, reachSize;

  always_comb begin
    gapInside   = sinceLast <= GAP_W'(burstGran);
    distReached = sinceLast >= GAP_W'(burstDist);
    burstMode   = burstSize >= SIZE_W'(2);
    if (groupCnt != '0 && gapInside)
      nextGroup = (groupCnt == GRP_MAX) ? GRP_MAX : groupCnt + 1'b1;
    else if (distReached)
      nextGroup = SIZE_W'(1);
    else
      nextGroup = '0;               // blocked until a quiet period of burstDist
    reachSize   = (nextGroup == burstSize) && (groupCnt != burstSize);
    strobes.hit = eventHit;
    strobes.inc = eventHit && (burstMode ? reachSize : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceLast <= GAP_MAX;
      groupCnt  <= '0;
    end else if (eventHit) begin
      sinceLast <= GAP_W'(1);
      groupCnt  <= nextGroup;
    end else if (sinceLast != GAP_MAX) begin
      sinceLast <= sinceLast + 1'b1;
    end
  end

  // A counted burst is never followed by another count on the very next cycle.
  p_single_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inc && burstMode) |=>
      !(strobes.inc && $stable(burstSize) && $stable(burstGran) && $stable(burstDist)));
endmodule

// File: rtl/bec_count_path.sv
module bec_count_path
  import bec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobes,
  input  logic             freezeCnt,
  input  logic             condEnable,
  output logic [CNT_W-1:0] countValue,
  output logic             ovfCondition
);
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         countQ <= '0;
    else if (strobes.inc && !freezeCnt) countQ <= countQ + 1'b1;
  end

  assign countValue   = countQ;
  assign ovfCondition = condEnable & countQ[CNT_W-1];

  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(freezeCnt) |-> countQ == $past(countQ));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == $past(countQ)) || (countQ == $past(countQ) + 1'b1));

  p_inc_from_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != $past(countQ)) |-> $past(strobes.hit));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(countQ) == '1 && $past(strobes.inc) && !$past(freezeCnt)) |-> countQ == '0);
endmodule

// File: rtl/burst_event_counter.sv
module burst_event_counter
  import bec_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 128,
  parameter int SIZE_W = 5,
  parameter int GRAN_W = 5,
  parameter int DIST_W = 6,
  localparam int SEL_W = $clog2(NUM_EV),
  localparam int HALF  = NUM_EV / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freezeCnt,
  input  logic              condEnable,
  input  logic [SEL_W-1:0]  eventSel,
  input  logic [SIZE_W-1:0] burstSize,
  input  logic [GRAN_W-1:0] burstGran,
  input  logic [DIST_W-1:0] burstDist,
  input  logic [HALF-1:0]   sharedEvents,
  input  logic [HALF-1:0]   chanEvents,
  output logic [CNT_W-1:0]  countValue,
  output logic              ovfCondition
);
  logic       eventHit;
  cntStrobe_t strobes;

  bec_event_mux #(.NUM_EV(NUM_EV)) i_mux (
    .eventSel(eventSel), .sharedEvents(sharedEvents),
    .chanEvents(chanEvents), .eventHit(eventHit));

  bec_burst_ctrl #(.SIZE_W(SIZE_W), .GRAN_W(GRAN_W), .DIST_W(DIST_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .eventHit(eventHit), .burstSize(burstSize),
    .burstGran(burstGran), .burstDist(burstDist), .strobes(strobes));

  bec_count_path #(.CNT_W(CNT_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .freezeCnt(freezeCnt),
    .condEnable(condEnable), .countValue(countValue), .ovfCondition(ovfCondition));
endmodule

// File: tb/test_burst_event_counter.sv
module test_burst_event_counter;
  localparam int CW = 8;   // reduced width so wrap and top bit are reachable

  logic clk = 1'b0, rstN = 1'b0, freezeCnt = 1'b0, condEnable = 1'b0;
  logic [6:0] eventSel = '0;
  logic [4:0] burstSize = '0, burstGran = '0;
  logic [5:0] burstDist = '0;
  logic [127:0] evBus = '0;
  logic [CW-1:0] countValue;
  logic ovfCondition;

  int checks = 0, errors = 0;
  int mCnt = 0, mCycle = 0, mLast = -1000, mGroup = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_event_counter #(.CNT_W(CW)) i_burst_event_counter (
    .clk(clk), .rstN(rstN), .freezeCnt(freezeCnt), .condEnable(condEnable),
    .eventSel(eventSel), .burstSize(burstSize), .burstGran(burstGran),
    .burstDist(burstDist), .sharedEvents(evBus[63:0]), .chanEvents(evBus[127:64]),
    .countValue(countValue), .ovfCondition(ovfCondition));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: occurrence times and group length kept as integers.
  always @(posedge clk) begin
    bit hit, inc;
    int gap;
    mCycle++;
    if (!rstN) begin
      mCnt = 0; mGroup = 0; mLast = mCycle - 1000;
    end else begin
      hit = evBus[eventSel];   // R2: shared 0..63, private k at 64+k
      inc = 0;
      if (hit) begin
        gap = mCycle - mLast;
        if (mGroup > 0 && gap <= burstGran) begin
          mGroup++;
          if (mGroup == burstSize) inc = 1;
        end else if (gap >= burstDist) mGroup = 1;
        else mGroup = 0;
        mLast = mCycle;
        if (burstSize < 2) inc = 1;
      end
      if (inc && !freezeCnt) mCnt = (mCnt + 1) % (1 << CW);
    end
    #2;
    if (!finished) begin
      check("R3/R7 per-cycle count", int'(countValue), mCnt);
      check("R5 per-cycle flag", int'(ovfCondition),
            int'(condEnable && mCnt >= (1 << (CW-1))));
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic hits(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      evBus[idx] = 1'b1;
      @(negedge clk);
      evBus[idx] = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1 check("R1 count in reset", int'(countValue), 0);
    check("R1 flag in reset", int'(ovfCondition), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1 check("R1 count after reset", int'(countValue), 0);

    // Plain counting on shared line 5 while line 6 also toggles.
    eventSel = 7'd5;
    for (int i = 0; i < 10; i++) begin
      evBus[5] = 1'b1; evBus[6] = i[0];
      @(negedge clk);
    end
    evBus[5] = 1'b0; evBus[6] = 1'b0;
    #1 check("R3 ten plain events", int'(countValue), 10);
    hits(6, 5);
    #1 check("R10 unselected line ignored", int'(countValue), 10);
    eventSel = 7'd67;
    hits(67, 4);
    hits(3, 4);
    #1 check("R2 private event 3 via 67", int'(countValue), 14);
    freezeCnt = 1'b1;
    hits(67, 6);
    #1 check("R4 frozen count holds", int'(countValue), 14);
    freezeCnt = 1'b0;
    hits(67, 2);
    #1 check("R4 resumes after freeze", int'(countValue), 16);

    // Top bit and wrap.
    doReset();
    eventSel = 7'd5;
    hits(5, 128);
    #1 check("R5 top bit set, count", int'(countValue), 128);
    check("R5 flag off when disabled", int'(ovfCondition), 0);
    condEnable = 1'b1;
    #1 check("R5 flag on when enabled", int'(ovfCondition), 1);
    hits(5, 127);
    #1 check("R6 all ones", int'(countValue), 255);
    hits(5, 1);
    #1 check("R6 wrap to zero", int'(countValue), 0);
    check("R5 flag clears after wrap", int'(ovfCondition), 0);
    condEnable = 1'b0;

    // Burst counting: size 3, granularity 2, distance 8.
    doReset();
    burstSize = 5'd3; burstGran = 5'd2; burstDist = 6'd8;
    idle(3);
    hits(5, 1); idle(1); hits(5, 1); idle(1); hits(5, 1);
    #1 check("R7 burst at gap equal to granularity", int'(countValue), 1);
    idle(1); hits(5, 1); idle(1); hits(5, 1);
    #1 check("R7 extra members not counted", int'(countValue), 1);
    idle(10); hits(5, 2);
    #1 check("R8 short group not counted", int'(countValue), 1);
    idle(10);
    hits(5, 1); idle(2); hits(5, 1); idle(2); hits(5, 1); idle(2); hits(5, 1);
    #1 check("R8 gap above granularity splits", int'(countValue), 1);
    idle(10); hits(5, 3);
    #1 check("R7 consecutive burst", int'(countValue), 2);
    idle(5); hits(5, 3);
    #1 check("R9 short quiet blocks burst", int'(countValue), 2);
    idle(7); hits(5, 3);
    #1 check("R9 gap equal to distance starts", int'(countValue), 3);
    idle(6); hits(5, 3);
    #1 check("R9 gap one below distance blocks", int'(countValue), 3);
    idle(12);
    freezeCnt = 1'b1; hits(5, 3); freezeCnt = 1'b0;
    #1 check("R4 burst while frozen", int'(countValue), 3);

    idle(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule